// File: doc/BRIEF.md
# Gaussian Smoothing Compressor-Tree Datapath

This block turns one 3x3 neighbourhood of 8-bit pixels into one smoothed 8-bit pixel. It uses a 1-2-1 binomial kernel in both directions. The kernel weights are powers of two, so each of the nine weighted terms is the pixel wired one or two places to the left, or not moved at all. No multiplier is used.

The nine terms are reduced to a sum vector and a carry vector in three levels, before any carry ripples:

- Level 1: two 4-2 compressors, with the centre term passing by.
- Level 2: one 4-2 compressor, with the centre term again passing by.
- Level 3: one 3:2 carry-save adder.

Each 4-2 compressor is built from multiplexers and XOR gates, not from two chained full adders. A single carry-propagate adder then adds the two vectors together with a rounding offset of half an LSB. A right shift by four performs the division by the kernel weight total of 16.

The window, its strobe and the result strobe are the whole interface. Line buffers, window assembly, edges of the frame and frame timing belong to the surrounding logic. A parameter selects between two variants:

- A pipelined tree, with a register after each level and a latency of three cycles.
- A purely combinational tree, with a latency of zero.

Top module: `gauss_tree_filter`

## Requirements
- R1: The window is packed row-major, with pixel k in bits [8k+7:8k] of `win_i` and pixel 4 as the centre. The result is (Σ w_k·p_k + 8) >> 4, where w_k is 4 for k=4, 2 for odd k, and 1 for k=0,2,6,8.
- R2: With PIPELINED=1, `out_valid_o` is asserted exactly three clock cycles after each cycle in which `in_valid_i` is high, and at no other time.
- R3: With PIPELINED=0, `out_valid_o` equals `in_valid_i`, and `pix_o` carries the R1 result of the current window in the same cycle.
- R4: A window whose nine pixels are all equal produces that same value, including all-0 and all-255.
- R5: The result never exceeds the largest pixel of its window and never falls below the smallest.
- R6: While reset is low, and after reset is released until new input arrives, `out_valid_o` is 0. A reset asserted with results in flight discards them.
- R7: With PIPELINED=1, `pix_o` keeps its last result in every cycle in which `out_valid_o` is 0, whatever `win_i` carries while `in_valid_i` is low.
- R8: Windows presented on consecutive cycles each produce one result, in input order, on consecutive cycles.
- R9: A weighted sum whose remainder modulo 16 is 8 or more rounds up, and one whose remainder is below 8 rounds down. For example, a single corner pixel of 8 gives 1, and a single corner pixel of 7 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid_i | input | 1 | Window strobe |
| win_i | input | 9*PIX_W | Nine window pixels, row-major, pixel 0 at the LSB end |
| out_valid_o | output | 1 | Result strobe |
| pix_o | output | PIX_W | Smoothed pixel |

## Verification
The hardest situations to reach from the ports are the rounding boundary and the bits at the top of the tree. Carries shifted out of the compressors must never be lost, and they only appear when many large terms line up. The vector table therefore places single corner pixels of 7 and 8 on either side of the rounding threshold, a lone saturated centre pixel, and a full-scale window that drives the sum to its maximum of 4088. Random windows are sent back-to-back and with gaps, so that a full pipeline, a draining pipeline and a reset that arrives mid-flight are all observed at the result port.

// File: rtl/gauss_pkg.sv
package gauss_pkg;
  // Right shift that divides by the kernel weight total (16).
  localparam int NORM_SH = 4;
  localparam int TAPS    = 9;
  localparam int CENTRE  = 4;

  // Left shift applied to tap k: corners 0, edges 1, centre 2.
  function automatic int tap_shift(input int k);
    if (k == CENTRE) return 2;
    else if ((k % 2) == 1) return 1;
    else return 0;
  endfunction
endpackage

// File: rtl/gauss_comp42.sv
// Mux-based 4-2 compressor across a vector; the carry output is pre-shifted.
module gauss_comp42 #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  logic [W:0]   chain;
  logic [W-1:0] cy_raw;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ab_x, cd_x, all_x;
    assign ab_x  = a_i[i] ^ b_i[i];
    assign cd_x  = c_i[i] ^ d_i[i];
    assign all_x = ab_x ^ cd_x;
    // lateral carry: majority of a,b,c selected by a^b
    assign chain[i+1] = ab_x ? c_i[i] : a_i[i];
    assign sum_o[i]   = all_x ^ chain[i];
    // second carry: majority of (a^b^c), d, cin selected by their parity
    assign cy_raw[i]  = all_x ? chain[i] : d_i[i];
  end

  assign cy_o = {cy_raw[W-2:0], 1'b0};
endmodule

// File: rtl/gauss_csa3.sv
// 3:2 carry-save adder across a vector; the carry output is pre-shifted.
module gauss_csa3 #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  logic [W-1:0] maj;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    assign maj[i]   = (a_i[i] & b_i[i]) | (c_i[i] & (a_i[i] ^ b_i[i]));
  end

  assign cy_o = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/gauss_lvl_reg.sv
// Optional level register: valid resets, data loads only with valid.
module gauss_lvl_reg #(
  parameter int W  = 12,
  parameter bit EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  if (EN) begin : g_reg
    logic         v_q;
    logic [W-1:0] d_q, d_nxt;

    always_comb begin
      d_nxt = d_q;
      if (v_i) d_nxt = d_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) v_q <= 1'b0;
      else         v_q <= v_i;
    end

    always_ff @(posedge clk_i) begin
      d_q <= d_nxt;
    end

    assign v_o = v_q;
    assign d_o = d_q;
  end else begin : g_wire
    assign v_o = v_i;
    assign d_o = d_i;
  end
endmodule

// File: rtl/gauss_rst_sync.sv
// Asserts asynchronously, deasserts on the second clock edge.
module gauss_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q, sync_nxt;

  always_comb sync_nxt = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_nxt;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/gauss_tree_filter.sv
module gauss_tree_filter
  import gauss_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter bit PIPELINED = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [TAPS*PIX_W-1:0] win_i,
  output logic                 out_valid_o,
  output logic [PIX_W-1:0]     pix_o
);
  localparam int SW = PIX_W + NORM_SH;
  localparam logic [SW-1:0] ROUND = SW'(1) << (NORM_SH - 1);

  logic rst_n_s;
  gauss_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_s));

  // Weighted terms by wiring shifts.
  logic [SW-1:0] term [TAPS];
  for (genvar k = 0; k < TAPS; k++) begin : g_term
    assign term[k] = SW'(win_i[k*PIX_W +: PIX_W]) << tap_shift(k);
  end

  // Level 1: 8 -> 4, centre passes by.
  logic [SW-1:0] l1_sa, l1_ca, l1_sb, l1_cb;
  gauss_comp42 #(.W(SW)) u_l1a (
    .a_i(term[0]), .b_i(term[1]), .c_i(term[2]), .d_i(term[3]),
    .sum_o(l1_sa), .cy_o(l1_ca));
  gauss_comp42 #(.W(SW)) u_l1b (
    .a_i(term[5]), .b_i(term[6]), .c_i(term[7]), .d_i(term[8]),
    .sum_o(l1_sb), .cy_o(l1_cb));

  logic          v1;
  logic [SW-1:0] r1_sa, r1_ca, r1_sb, r1_cb, r1_ctr;
  gauss_lvl_reg #(.W(5*SW), .EN(PIPELINED)) u_r1 (
    .clk_i(clk_i), .rst_ni(rst_n_s), .v_i(in_valid_i),
    .d_i({l1_sa, l1_ca, l1_sb, l1_cb, term[CENTRE]}),
    .v_o(v1), .d_o({r1_sa, r1_ca, r1_sb, r1_cb, r1_ctr}));

  // Level 2: 4 -> 2, centre passes by.
  logic [SW-1:0] l2_s, l2_c;
  gauss_comp42 #(.W(SW)) u_l2 (
    .a_i(r1_sa), .b_i(r1_ca), .c_i(r1_sb), .d_i(r1_cb),
    .sum_o(l2_s), .cy_o(l2_c));

  logic          v2;
  logic [SW-1:0] r2_s, r2_c, r2_ctr;
  gauss_lvl_reg #(.W(3*SW), .EN(PIPELINED)) u_r2 (
    .clk_i(clk_i), .rst_ni(rst_n_s), .v_i(v1),
    .d_i({l2_s, l2_c, r1_ctr}),
    .v_o(v2), .d_o({r2_s, r2_c, r2_ctr}));

  // Level 3: 3 -> 2.
  logic [SW-1:0] l3_s, l3_c;
  gauss_csa3 #(.W(SW)) u_l3 (
    .a_i(r2_s), .b_i(r2_c), .c_i(r2_ctr),
    .sum_o(l3_s), .cy_o(l3_c));

  logic          v3;
  logic [SW-1:0] r3_s, r3_c;
  gauss_lvl_reg #(.W(2*SW), .EN(PIPELINED)) u_r3 (
    .clk_i(clk_i), .rst_ni(rst_n_s), .v_i(v2),
    .d_i({l3_s, l3_c}),
    .v_o(v3), .d_o({r3_s, r3_c}));

  // Single carry-propagate adder with rounding, then normalise.
  logic [SW-1:0] total;
  assign total       = r3_s + r3_c + ROUND;
  assign pix_o       = total[SW-1:NORM_SH];
  assign out_valid_o = v3;
endmodule

// File: rtl/gauss_tree_chk.sv
module gauss_tree_chk #(
  parameter int PIX_W     = 8,
  parameter bit PIPELINED = 1'b1,
  parameter int SW        = PIX_W + 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [9*PIX_W-1:0] win,
  input logic               out_valid,
  input logic [PIX_W-1:0]   pix,
  input logic [SW-1:0]      total
);
  localparam logic [SW-1:0] TOP = SW'((1 << PIX_W) - 1) * SW'(16) + SW'(8);

  logic [1:0] age;
  logic       loaded;
  logic [PIX_W-1:0] mx, mn;
  logic       flat;

  always_comb begin
    mx   = win[PIX_W-1:0];
    mn   = win[PIX_W-1:0];
    flat = 1'b1;
    for (int k = 1; k < 9; k++) begin
      if (win[k*PIX_W +: PIX_W] > mx) mx = win[k*PIX_W +: PIX_W];
      if (win[k*PIX_W +: PIX_W] < mn) mn = win[k*PIX_W +: PIX_W];
      if (win[k*PIX_W +: PIX_W] != win[PIX_W-1:0]) flat = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age    <= 2'd0;
      loaded <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (out_valid)   loaded <= 1'b1;
    end
  end

  // R6
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> total <= TOP);

  if (PIPELINED) begin : g_pipe
    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R4
    flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && out_valid && $past(flat, 3)) |-> (pix == $past(win[PIX_W-1:0], 3)));

    // R5
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && out_valid) |-> (pix <= $past(mx, 3) && pix >= $past(mn, 3)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded && !out_valid) |-> $stable(pix));
  end else begin : g_comb
    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);

    // R5
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pix <= mx && pix >= mn));
  end
endmodule

bind gauss_tree_filter gauss_tree_chk #(
  .PIX_W(PIX_W), .PIPELINED(PIPELINED), .SW(PIX_W + 4)
) u_chk (
  .clk(clk_i), .rst_n(rst_n_s), .in_valid(in_valid_i), .win(win_i),
  .out_valid(out_valid_o), .pix(pix_o), .total(total)
);

// File: tb/sim_gauss_tree_filter.sv
module sim_gauss_tree_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [71:0] win;
  logic        ov0, ov1;
  logic [7:0]  px0, px1;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gauss_tree_filter #(.PIX_W(8), .PIPELINED(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .win_i(win),
    .out_valid_o(ov0), .pix_o(px0));

  gauss_tree_filter #(.PIX_W(8), .PIPELINED(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .win_i(win),
    .out_valid_o(ov1), .pix_o(px1));

  // stimulus table, pixel 0 at LSB
  localparam logic [71:0] VEC [8] = '{
    72'h00_00_00_00_00_00_00_00_08,  // R9 corner 8 -> 1
    72'h00_00_00_00_00_00_00_00_07,  // R9 corner 7 -> 0
    72'h00_00_00_00_FF_00_00_00_00,  // centre only
    72'hFF_FF_FF_FF_FF_FF_FF_FF_FF,  // full scale
    72'h01_02_03_04_05_06_07_08_09,
    72'h00_FF_00_FF_00_FF_00_FF_00,  // edges only
    72'hFF_00_FF_00_00_00_FF_00_FF,  // corners only
    72'h10_20_30_40_50_60_70_80_90
  };

  function automatic int ref_pix(input logic [71:0] w);
    int s = 0;
    for (int k = 0; k < 9; k++) begin
      int wt = (k == 4) ? 4 : ((k % 2 == 1) ? 2 : 1);
      s += int'(w[k*8 +: 8]) * wt;
    end
    return (s + 8) >> 4;
  endfunction

  // expected-result queue for the pipelined instance
  int qv [256];
  int qc [256];
  int head = 0, tail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor at the falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (ov0) begin
        if (head == tail) check(1'b0, "R2 unexpected valid", 1, 0);
        else begin
          check(px0 == 8'(qv[head % 256]), "R1/R8 pipelined result", px0, qv[head % 256]);
          check(cyc == qc[head % 256] + 3, "R2 latency", cyc - qc[head % 256], 3);
          head++;
        end
      end
      if (in_valid) begin
        check(ov1 == 1'b1, "R3 comb valid", ov1, 1);
        check(px1 == 8'(ref_pix(win)), "R3 comb result", px1, ref_pix(win));
      end
    end
  end

  task automatic send(input logic [71:0] w);
    @(posedge clk); #1;
    in_valid = 1'b1;
    win      = w;
    qv[tail % 256] = ref_pix(w);
    qc[tail % 256] = cyc;
    tail++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0; in_valid = 1'b0; win = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ov0 == 1'b0, "R6 reset state", ov0, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    check(ov0 == 1'b0, "R6 idle after reset", ov0, 0);

    // R8: table back-to-back, R1, R9
    for (int i = 0; i < 8; i++) send(VEC[i]);
    idle(5);
    check(ref_pix(VEC[0]) == 1 && ref_pix(VEC[1]) == 0, "R9 reference", ref_pix(VEC[0]), 1);

    // R4 flat windows
    send('0);
    send({9{8'hFF}});
    send({9{8'h5A}});
    idle(5);

    // random windows, with gaps
    for (int i = 0; i < 60; i++) begin
      send({$urandom, $urandom, $urandom});
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(5);

    // R7 hold while invalid
    @(negedge clk); held = px0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1; in_valid = 1'b0; win = {$urandom, $urandom, $urandom};
      @(negedge clk);
      check(px0 == held && !ov0, "R7 hold", px0, held);
    end

    // R6 reset mid-flight discards
    send({9{8'h33}});
    send({9{8'h44}});
    @(posedge clk); #1; in_valid = 1'b0; rst_n = 1'b0;
    head = tail;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(ov0 == 1'b0, "R6 flush", ov0, 0);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    idle(6);
    @(negedge clk);
    check(ov0 == 1'b0, "R6 no stale result", ov0, 0);
    send(VEC[3]);
    idle(5);
    check(head == tail, "R2 all results seen", head, tail);
    finish_run();
  end
endmodule